// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from power-up to a usable state. After reset it holds the command bus at no-operation with clock-enable and data mask high for the power-up pause. It then closes every bank and runs the required batch of auto-refresh commands. Finally it loads the mode register with a word assembled from configuration inputs. Every wait is a cycle count derived from the clock frequency and a time in nanoseconds or microseconds.

Once the mode-register load has settled, the block raises a sticky ready flag and releases the data mask. From then on it emits a single-cycle refresh request at the average interval needed to cover every row in the refresh window. A separate access controller, not part of this block, consumes that request.

Top module: `sdram_init_seq`

## Requirements
- R1: Reset is synchronous and active low. While it is applied, the outputs show no-operation (chip select low, row strobe, column strobe and write enable high), clock-enable high, data mask high, address and bank zero, and both ready and refresh request low.
- R2: The outputs stay at no-operation for PAUSE_CYC cycles after reset is released, where PAUSE_CYC = PAUSE_US × CLK_MHZ. In the following cycle the block drives the close-all-banks command: chip select, row strobe and write enable low, column strobe high, with address bit 10 high.
- R3: The first auto-refresh (chip select, row strobe and column strobe low, write enable high) comes TRP_CYC cycles after the close-all command. There are NUM_REFRESH auto-refreshes in total, each TRC_CYC cycles after the one before it. A cycle count is ceil(ns × CLK_MHZ / 1000), with a minimum of 1.
- R4: The mode-register load comes TRC_CYC cycles after the last auto-refresh. It has chip select, row strobe, column strobe and write enable all low and the bank bits at zero.
- R5: The mode word carries the burst length on address bits 2..0, the burst order on bit 3 (0 sequential, 1 interleaved), the read latency code on bits 6..4 and the single-write select on bit 9. Bits 7, 8, 10 and 11 are zero. The configuration inputs are used only in the cycle in which the load is issued, and their values at any other time have no effect.
- R6: The ready flag rises TRSC_CYC cycles after the mode-register load, with only no-operation cycles in between. It stays high, with no further commands, until the next reset.
- R7: The data mask is high from reset until ready rises and low from then on. Clock-enable is high at all times.
- R8: The refresh request is a one-cycle pulse. Its first pulse comes REFI_CYC cycles after ready rises, and it repeats every REFI_CYC cycles after that, where REFI_CYC = floor(REFI_NS × CLK_MHZ / 1000). It never pulses while ready is low.
- R9: Address and bank outputs are zero in every no-operation and auto-refresh cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for mode bits 2..0 |
| cfg_interleave | input | 1 | Burst order for mode bit 3 |
| cfg_read_lat | input | 3 | Read latency code for mode bits 6..4 |
| cfg_single_wr | input | 1 | Single-write select for mode bit 9 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 1 | Data mask |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed address |
| init_done | output | 1 | Sticky ready flag |
| refresh_req | output | 1 | Periodic one-cycle refresh request |

## Verification
The hardest case to reach from the ports is showing that the configuration inputs matter only in the single mode-load cycle. That cycle falls more than twenty thousand clocks after reset. The stimulus changes the configuration on every clock early in the pause, then settles it, and checks the address bus on every cycle, so any leak of configuration into a no-operation or refresh cycle is caught. A second reset is applied while the refresh ticks are running, and the sequence is repeated with a different configuration, including the full-page length code. This shows that ready and the tick counter both restart from scratch.

// File: rtl/sdram_init_pkg.sv
// Shared types and helpers for the SDRAM initialization sequencer.
// Assumes a 4-bit command encoding ordered {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = sd_cmd_t'(4'b0111);
    localparam sd_cmd_t CMD_PALL = sd_cmd_t'(4'b0010);
    localparam sd_cmd_t CMD_AREF = sd_cmd_t'(4'b0001);
    localparam sd_cmd_t CMD_MLOAD = sd_cmd_t'(4'b0000);

    typedef enum logic [2:0] {
        ST_WAIT_PALL,
        ST_WAIT_AREF,
        ST_WAIT_MLOAD,
        ST_WAIT_RDY,
        ST_READY
    } init_state_t;

    // Convert a time in ns to whole clock cycles, rounded up, at least one.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Assemble the 12-bit mode word; unused positions are zero.
    function automatic logic [11:0] mode_word(input logic [2:0] blen,
                                              input logic       ilv,
                                              input logic [2:0] rlat,
                                              input logic       swr);
        logic [11:0] w;
        w       = '0;
        w[2:0]  = blen;
        w[3]    = ilv;
        w[6:4]  = rlat;
        w[9]    = swr;
        return w;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
// Loadable down-counter that flags when it reaches zero.
// Assumes the owner reloads it in the cycle it reads expired high.
module sdram_init_timer #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Count down to zero; a load overrides counting.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= W'(RST_VAL);
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_init_fsm.sv
// Ordered command sequencer: close-all, N auto-refreshes, mode load, ready.
// Assumes the timer was preset by reset to cover the power-up pause.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int W           = 16,
    parameter int NUM_REFRESH = 8,
    parameter int TRP_CYC     = 2,
    parameter int TRC_CYC     = 7,
    parameter int TRSC_CYC    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   cfg_burst_len,
    input  logic         cfg_interleave,
    input  logic [2:0]   cfg_read_lat,
    input  logic         cfg_single_wr,
    input  logic         expired,
    output logic         load,
    output logic [W-1:0] load_val,
    output sd_cmd_t      cmd,
    output logic [11:0]  addr,
    output logic         cke,
    output logic         dqm,
    output logic         done
);

    localparam int RCW = $clog2(NUM_REFRESH + 1);

    init_state_t    state, nxt_state;
    logic [RCW-1:0] ref_cnt, nxt_ref_cnt;
    sd_cmd_t        nxt_cmd;
    logic [11:0]    nxt_addr;

    // Choose the next command and the gap to wait after it.
    always_comb begin
        nxt_state   = state;
        nxt_ref_cnt = ref_cnt;
        nxt_cmd     = CMD_NOP;
        nxt_addr    = '0;
        load        = 1'b0;
        load_val    = '0;
        case (state)
            ST_WAIT_PALL: if (expired) begin
                nxt_cmd      = CMD_PALL;
                nxt_addr[10] = 1'b1;
                load         = 1'b1;
                load_val     = W'(TRP_CYC - 1);
                nxt_state    = ST_WAIT_AREF;
            end
            ST_WAIT_AREF: if (expired) begin
                nxt_cmd     = CMD_AREF;
                load        = 1'b1;
                load_val    = W'(TRC_CYC - 1);
                nxt_ref_cnt = ref_cnt + 1'b1;
                if (ref_cnt == RCW'(NUM_REFRESH - 1)) nxt_state = ST_WAIT_MLOAD;
            end
            ST_WAIT_MLOAD: if (expired) begin
                nxt_cmd   = CMD_MLOAD;
                nxt_addr  = mode_word(cfg_burst_len, cfg_interleave,
                                      cfg_read_lat, cfg_single_wr);
                load      = 1'b1;
                load_val  = W'(TRSC_CYC - 1);
                nxt_state = ST_WAIT_RDY;
            end
            ST_WAIT_RDY: if (expired) nxt_state = ST_READY;
            default: ;
        endcase
    end

    // Register state and every pin-facing output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_WAIT_PALL;
            ref_cnt <= '0;
            cmd     <= CMD_NOP;
            addr    <= '0;
            cke     <= 1'b1;
            dqm     <= 1'b1;
            done    <= 1'b0;
        end else begin
            state   <= nxt_state;
            ref_cnt <= nxt_ref_cnt;
            cmd     <= nxt_cmd;
            addr    <= nxt_addr;
            cke     <= 1'b1;
            dqm     <= (nxt_state != ST_READY);
            done    <= (nxt_state == ST_READY);
        end
    end

    // R2: close-all always carries address bit 10.
    a_r2_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PALL) |-> addr[10]);
    // R5: reserved mode bits stay zero during the load.
    a_r5_mode_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MLOAD) |-> (addr[11:10] == 2'b00 && addr[8:7] == 2'b00));
    // R6: ready never drops before reset.
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    // R6: once ready, only no-operation appears.
    a_r6_quiet_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd == CMD_NOP));
    // R7: mask held high while not ready.
    a_r7_mask_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> dqm);

endmodule

// File: rtl/sdram_refresh_tick.sv
// Periodic one-cycle refresh request, running only while enabled.
// Assumes PERIOD >= 2; the count restarts whenever enable is low.
module sdram_refresh_tick #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);

    localparam int CW = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    // Count enabled cycles and pulse at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(PERIOD - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R8: request only while enabled, and only one cycle wide.
    a_r8_tick_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> enable);
    a_r8_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sdram_init_seq.sv
// Top of the SDRAM power-up sequencer: derives cycle counts from the clock
// frequency, wires the pause/gap timer, the command FSM and the refresh tick.
// Assumes one clock domain and that the configuration is steady at mode load.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int PAUSE_US    = 200,
    parameter int TRP_NS      = 20,
    parameter int TRC_NS      = 65,
    parameter int TRSC_CYC    = 2,
    parameter int REFI_NS     = 15600,
    parameter int NUM_REFRESH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_burst_len,
    input  logic        cfg_interleave,
    input  logic [2:0]  cfg_read_lat,
    input  logic        cfg_single_wr,
    output logic        sd_cs_n,
    output logic        sd_ras_n,
    output logic        sd_cas_n,
    output logic        sd_we_n,
    output logic        sd_cke,
    output logic        sd_dqm,
    output logic [1:0]  sd_ba,
    output logic [11:0] sd_addr,
    output logic        init_done,
    output logic        refresh_req
);

    localparam int PAUSE_CYC = PAUSE_US * CLK_MHZ;
    localparam int TRP_CYC   = ns_to_cyc(TRP_NS, CLK_MHZ);
    localparam int TRC_CYC   = ns_to_cyc(TRC_NS, CLK_MHZ);
    localparam int REFI_CYC  = (REFI_NS * CLK_MHZ) / 1000;
    localparam int MAXGAP    = (PAUSE_CYC > TRC_CYC) ? PAUSE_CYC : TRC_CYC;
    localparam int TW        = $clog2(MAXGAP + 1) + 1;

    logic          expired, load;
    logic [TW-1:0] load_val;
    sd_cmd_t       cmd;

    sdram_init_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .expired(expired)
    );

    sdram_init_fsm #(
        .W(TW), .NUM_REFRESH(NUM_REFRESH), .TRP_CYC(TRP_CYC),
        .TRC_CYC(TRC_CYC), .TRSC_CYC(TRSC_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
        .cfg_read_lat(cfg_read_lat), .cfg_single_wr(cfg_single_wr),
        .expired(expired), .load(load), .load_val(load_val),
        .cmd(cmd), .addr(sd_addr), .cke(sd_cke), .dqm(sd_dqm),
        .done(init_done)
    );

    sdram_refresh_tick #(.PERIOD(REFI_CYC)) u_tick (
        .clk(clk), .rst_n(rst_n), .enable(init_done), .tick(refresh_req)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_ba    = 2'b00;

endmodule

// File: tb/sdram_init_seq_tb.sv
// Cycle-by-cycle behavioural model of the init schedule, compared every clock.
module sdram_init_seq_tb;

    localparam int P    = 200 * 100;
    localparam int TRP  = (20 * 100 + 999) / 1000;
    localparam int TRC  = (65 * 100 + 999) / 1000;
    localparam int TRSC = 2;
    localparam int REFI = 15600 * 100 / 1000;
    localparam int NREF = 8;
    localparam int T_PALL  = P;
    localparam int T_REF0  = P + TRP;
    localparam int T_MLOAD = T_REF0 + NREF * TRC;
    localparam int T_DONE  = T_MLOAD + TRSC;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [2:0]  cfg_burst_len = 3'd0;
    logic        cfg_interleave = 1'b0;
    logic [2:0]  cfg_read_lat = 3'd0;
    logic        cfg_single_wr = 1'b0;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_dqm;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic        init_done, refresh_req;

    sdram_init_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
        .cfg_read_lat(cfg_read_lat), .cfg_single_wr(cfg_single_wr),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_cke(sd_cke), .sd_dqm(sd_dqm),
        .sd_ba(sd_ba), .sd_addr(sd_addr),
        .init_done(init_done), .refresh_req(refresh_req)
    );

    int  n = 0;
    bit  armed = 1'b0;
    int  checks = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, n, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Edges seen with reset released since the last reset.
    always @(posedge clk) begin
        n     <= rst_n ? n + 1 : 0;
        armed <= 1'b1;
    end

    // Reference model and comparison, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            logic [3:0]  e_cmd;
            logic [11:0] e_addr;
            logic        e_done, e_tick;
            string       tag;
            e_cmd  = 4'b0111;
            e_addr = 12'h000;
            tag    = (n == 0) ? "R1" : (n < T_PALL) ? "R2" : (n < T_MLOAD) ? "R3" : "R6";
            if (n == T_PALL) begin
                e_cmd = 4'b0010; e_addr = 12'h400; tag = "R2";
            end else if (n >= T_REF0 && n < T_MLOAD && (n - T_REF0) % TRC == 0) begin
                e_cmd = 4'b0001; tag = "R3";
            end else if (n == T_MLOAD) begin
                e_cmd  = 4'b0000; tag = "R4";
                e_addr = {2'b00, cfg_single_wr, 2'b00, cfg_read_lat, cfg_interleave, cfg_burst_len};
            end
            e_done = (n >= T_DONE);
            e_tick = (n > T_DONE) && ((n - T_DONE) % REFI == 0);
            check(tag, {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, e_cmd});
            check((n == T_MLOAD) ? "R5" : (n == 0) ? "R1" : "R9", {20'd0, sd_addr}, {20'd0, e_addr});
            check((n == T_MLOAD) ? "R4" : "R9", {30'd0, sd_ba}, 32'd0);
            check((n == 0) ? "R1" : "R7", {31'd0, sd_cke}, 32'd1);
            check((n == 0) ? "R1" : "R7", {31'd0, sd_dqm}, {31'd0, !e_done});
            check((n == 0) ? "R1" : "R6", {31'd0, init_done}, {31'd0, e_done});
            check((n == 0) ? "R1" : "R8", {31'd0, refresh_req}, {31'd0, e_tick});
        end
    end

    // Stimulus: two full sequences with different configurations.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R5: configuration churn during the pause must not reach the bus.
        for (int k = 0; k < 64; k++) begin
            @(posedge clk);
            #1;
            cfg_burst_len  = 3'(k);
            cfg_interleave = k[1];
            cfg_read_lat   = 3'(k >> 2);
            cfg_single_wr  = k[0];
        end
        cfg_burst_len = 3'b010; cfg_interleave = 1'b1;
        cfg_read_lat  = 3'b011; cfg_single_wr  = 1'b1;
        while (n < T_DONE + 2 * REFI + 5) @(posedge clk);
        // R1: synchronous reset in the middle of the refresh ticks.
        #1 rst_n = 1'b0;
        cfg_burst_len = 3'b111; cfg_interleave = 1'b0;
        cfg_read_lat  = 3'b010; cfg_single_wr  = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        while (n < T_DONE + 2 * REFI + 3) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (120000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, actual timeout expected finish");
        finish_run();
    end

endmodule